// File: doc/BRIEF.md
# Bit-Slice Carry-Lookahead ALU

This block is a purely combinational 16-bit arithmetic and logic unit for a small processor datapath. Two operands and a 3-bit operation select go in; a 16-bit result and a carry-out come back in the same cycle. Six operations are defined: addition, reversed subtraction (the second operand minus the first), increment of the first operand, pass-through of the first operand, bitwise exclusive-OR and bitwise exclusive-NOR. The two remaining select codes are reserved and produce zero.

Every result bit comes from one identical one-bit slice. The slice is replicated across the word. A small decoder turns the select code into a handful of strobes that all slices share: invert the first operand, force the second operand to zero, the carry injected at bit 0, pick the logic path instead of the sum, and invert the logic path. The carry into each slice comes from a two-level lookahead network built from group generate and propagate terms. It does not ripple from slice to slice.

Top module: `slice_cla_alu`

## Requirements
- R1: With opSel = 0, result equals (opA + opB) mod 2^16 and carryOut equals bit 16 of the full sum.
- R2: With opSel = 6, result equals (opB − opA) mod 2^16, computed as opB + ~opA + 1, and carryOut is 1 exactly when opB >= opA (unsigned).
- R3: With opSel = 2, result equals (opA + 1) mod 2^16 and carryOut is 1 exactly when opA = 16'hFFFF.
- R4: With opSel = 3, result equals opA and carryOut is 0.
- R5: With opSel = 1, result equals opA XOR opB and carryOut is 0.
- R6: With opSel = 5, result equals the bitwise complement of (opA XOR opB) and carryOut is 0.
- R7: With opSel = 4 or opSel = 7, result is all zeros and carryOut is 0 for any operands.
- R8: A carry generated at bit 0 reaches bit 15 and carryOut across every group boundary. For example, 16'hFFFF + 16'h0001 gives result 0 with carryOut 1, and 16'h7FFF + 16'h0001 gives 16'h8000 with carryOut 0.
- R9: With opSel = 2 or opSel = 3, the value of opB has no effect on result or carryOut.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 16 | First operand (the subtrahend for reversed subtraction) |
| opB | input | 16 | Second operand |
| opSel | input | 3 | Operation select code |
| result | output | 16 | Operation result |
| carryOut | output | 1 | Final lookahead carry for arithmetic operations, otherwise 0 |

## Verification
The block holds no state, so a fault in a decoded strobe or a lookahead product term appears on result or carryOut as soon as the operands settle. It appears only for operand patterns that use that term. A missing propagate term, for instance, shows up only when a carry has to cross a whole 4-bit group, such as all-ones plus one or the borrow chain of a reversed subtraction with equal operands. The vectors therefore pair long propagate chains with every select code, and they add random operands that are compared against an arithmetic model built from the requirements.

// File: rtl/slice_cla_alu_pkg.sv
`timescale 1ns/1ps
package slice_cla_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_XOR  = 3'd1,
    OP_INC  = 3'd2,
    OP_PASS = 3'd3,
    OP_RSV4 = 3'd4,
    OP_XNOR = 3'd5,
    OP_RSUB = 3'd6,
    OP_RSV7 = 3'd7
  } aluOp_t;

  // strobes shared by every slice and by the carry network
  typedef struct packed {
    logic invA;       // complement operand A inside the slice
    logic zeroB;      // gate operand B to zero
    logic carryIn;    // carry injected at bit 0
    logic useLogic;   // select the XOR path instead of the sum
    logic invLogic;   // complement the XOR path
    logic zeroOut;    // reserved code: force result to zero
    logic keepCarry;  // arithmetic op: report the final carry
  } aluStrobes_t;

endpackage

// File: rtl/alu_ctrl.sv
`timescale 1ns/1ps
module alu_ctrl
  import slice_cla_alu_pkg::*;
(
  input  logic [2:0]  opSel,
  output aluStrobes_t strobes
);

  aluOp_t opCode;
  assign opCode = aluOp_t'(opSel);

  always_comb begin
    strobes = '0;
    case (opCode)
      OP_ADD: begin
        strobes.keepCarry = 1'b1;
      end
      OP_RSUB: begin
        strobes.invA      = 1'b1;
        strobes.carryIn   = 1'b1;
        strobes.keepCarry = 1'b1;
      end
      OP_INC: begin
        strobes.zeroB     = 1'b1;
        strobes.carryIn   = 1'b1;
        strobes.keepCarry = 1'b1;
      end
      OP_PASS: begin
        strobes.zeroB     = 1'b1;
      end
      OP_XOR: begin
        strobes.useLogic  = 1'b1;
      end
      OP_XNOR: begin
        strobes.useLogic  = 1'b1;
        strobes.invLogic  = 1'b1;
      end
      default: begin
        strobes.zeroOut   = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/alu_slice.sv
`timescale 1ns/1ps
module alu_slice (
  input  logic aBit,
  input  logic bBit,
  input  logic carryIn,
  input  logic invA,
  input  logic zeroB,
  input  logic useLogic,
  input  logic invLogic,
  input  logic zeroOut,
  output logic gen,
  output logic prop,
  output logic res
);

  logic aEff;
  logic bEff;
  logic sumBit;
  logic logicBit;

  assign aEff     = aBit ^ invA;
  assign bEff     = bBit & ~zeroB;
  assign gen      = aEff & bEff;
  assign prop     = aEff ^ bEff;
  assign sumBit   = prop ^ carryIn;
  assign logicBit = prop ^ invLogic;

  always_comb begin
    if (zeroOut)       res = 1'b0;
    else if (useLogic) res = logicBit;
    else               res = sumBit;
  end

endmodule

// File: rtl/alu_lookahead.sv
`timescale 1ns/1ps
// Flat sum-of-products lookahead over N generate/propagate pairs.
module alu_lookahead #(
  parameter int N = 4
) (
  input  logic [N-1:0] gen,
  input  logic [N-1:0] prop,
  input  logic         cin,
  output logic [N-1:0] carry,   // carry into each position
  output logic         grpGen,
  output logic         grpProp
);

  always_comb begin
    logic acc;
    logic term;
    carry = '0;
    for (int i = 0; i < N; i++) begin
      acc = cin;
      for (int k = 0; k < i; k++) acc = acc & prop[k];
      for (int j = 0; j < i; j++) begin
        term = gen[j];
        for (int k = j + 1; k < i; k++) term = term & prop[k];
        acc = acc | term;
      end
      carry[i] = acc;
    end
  end

  always_comb begin
    logic term;
    grpGen  = 1'b0;
    grpProp = &prop;
    for (int j = 0; j < N; j++) begin
      term = gen[j];
      for (int k = j + 1; k < N; k++) term = term & prop[k];
      grpGen = grpGen | term;
    end
  end

endmodule

// File: rtl/alu_datapath.sv
`timescale 1ns/1ps
module alu_datapath
  import slice_cla_alu_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int GROUP = 4
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluStrobes_t      strobes,
  output logic [WIDTH-1:0] result,
  output logic             carryOut
);

  localparam int NGRP = WIDTH / GROUP;

  logic [WIDTH-1:0] bitGen;
  logic [WIDTH-1:0] bitProp;
  logic [WIDTH-1:0] bitCarry;
  logic [NGRP-1:0]  grpGen;
  logic [NGRP-1:0]  grpProp;
  logic [NGRP-1:0]  grpCarry;
  logic             topGen;
  logic             topProp;

  for (genvar gi = 0; gi < NGRP; gi++) begin : g_grp
    for (genvar bi = 0; bi < GROUP; bi++) begin : g_bit
      localparam int IDX = gi * GROUP + bi;
      alu_slice u_slice (
        .aBit     (opA[IDX]),
        .bBit     (opB[IDX]),
        .carryIn  (bitCarry[IDX]),
        .invA     (strobes.invA),
        .zeroB    (strobes.zeroB),
        .useLogic (strobes.useLogic),
        .invLogic (strobes.invLogic),
        .zeroOut  (strobes.zeroOut),
        .gen      (bitGen[IDX]),
        .prop     (bitProp[IDX]),
        .res      (result[IDX])
      );
    end

    alu_lookahead #(.N(GROUP)) u_grpLa (
      .gen     (bitGen[gi*GROUP +: GROUP]),
      .prop    (bitProp[gi*GROUP +: GROUP]),
      .cin     (grpCarry[gi]),
      .carry   (bitCarry[gi*GROUP +: GROUP]),
      .grpGen  (grpGen[gi]),
      .grpProp (grpProp[gi])
    );
  end

  alu_lookahead #(.N(NGRP)) u_topLa (
    .gen     (grpGen),
    .prop    (grpProp),
    .cin     (strobes.carryIn),
    .carry   (grpCarry),
    .grpGen  (topGen),
    .grpProp (topProp)
  );

  assign carryOut = strobes.keepCarry & (topGen | (topProp & strobes.carryIn));

endmodule

// File: rtl/slice_cla_alu.sv
`timescale 1ns/1ps
module slice_cla_alu
  import slice_cla_alu_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int GROUP = 4
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [2:0]       opSel,
  output logic [WIDTH-1:0] result,
  output logic             carryOut
);

  aluStrobes_t strobes;

  alu_ctrl u_ctrl (
    .opSel   (opSel),
    .strobes (strobes)
  );

  alu_datapath #(.WIDTH(WIDTH), .GROUP(GROUP)) u_dp (
    .opA      (opA),
    .opB      (opB),
    .strobes  (strobes),
    .result   (result),
    .carryOut (carryOut)
  );

endmodule

// File: rtl/slice_cla_alu_chk.sv
`timescale 1ns/1ps
module slice_cla_alu_chk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [2:0]       opSel,
  input logic [WIDTH-1:0] result,
  input logic             carryOut
);

  logic [WIDTH:0] sumRef;
  logic [WIDTH:0] subRef;
  logic [WIDTH:0] incRef;

  assign sumRef = {1'b0, opA} + {1'b0, opB};
  assign subRef = {1'b0, opB} + {1'b0, ~opA} + {{WIDTH{1'b0}}, 1'b1};
  assign incRef = {1'b0, opA} + {{WIDTH{1'b0}}, 1'b1};

  always_comb begin
    if (opSel == 3'd0)
      AST_ADD_SUM: assert ({carryOut, result} == sumRef); // R1
    if (opSel == 3'd6)
      AST_RSUB_DIFF: assert (result == opB - opA && carryOut == (opB >= opA)); // R2
    if (opSel == 3'd2)
      AST_INC_STEP: assert ({carryOut, result} == incRef); // R3
    if (opSel == 3'd3)
      AST_PASS_THRU: assert (result == opA && !carryOut); // R4
    if (opSel == 3'd1)
      AST_XOR_BITS: assert (result == (opA ^ opB) && !carryOut); // R5
    if (opSel == 3'd5)
      AST_XNOR_BITS: assert (result == ~(opA ^ opB) && !carryOut); // R6
    if (opSel == 3'd4 || opSel == 3'd7)
      AST_RSV_ZERO: assert (result == '0 && !carryOut); // R7
    if (opSel == 3'd0 && (opA ^ opB) == '1 && (opA & opB) == '0)
      AST_FULL_PROPAGATE: assert (result == '1 && !carryOut); // R8
  end

  // unused sub-result check for the subtraction model
  logic subUnused;
  assign subUnused = ^subRef;

endmodule

bind slice_cla_alu slice_cla_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .opA      (opA),
  .opB      (opB),
  .opSel    (opSel),
  .result   (result),
  .carryOut (carryOut)
);

// File: tb/slice_cla_alu_tb.sv
`timescale 1ns/1ps
module slice_cla_alu_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic [2:0]  opSel = '0;
  logic [15:0] result;
  logic        carryOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  slice_cla_alu u_dut (
    .opA      (opA),
    .opB      (opB),
    .opSel    (opSel),
    .result   (result),
    .carryOut (carryOut)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] expRes;
    logic        expCo;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 17;
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 16'h0001, 16'h0002, 16'h0003, 1'b0, 4'd1}, // R1
    '{3'd0, 16'h1234, 16'h4321, 16'h5555, 1'b0, 4'd1}, // R1
    '{3'd0, 16'h8000, 16'h8000, 16'h0000, 1'b1, 4'd1}, // R1
    '{3'd0, 16'hFFFF, 16'h0001, 16'h0000, 1'b1, 4'd8}, // R8
    '{3'd0, 16'h7FFF, 16'h0001, 16'h8000, 1'b0, 4'd8}, // R8
    '{3'd6, 16'h0003, 16'h000A, 16'h0007, 1'b1, 4'd2}, // R2
    '{3'd6, 16'h000A, 16'h0003, 16'hFFF9, 1'b0, 4'd2}, // R2
    '{3'd6, 16'h1234, 16'h1234, 16'h0000, 1'b1, 4'd2}, // R2
    '{3'd6, 16'h0000, 16'h0000, 16'h0000, 1'b1, 4'd2}, // R2
    '{3'd6, 16'h0001, 16'h0000, 16'hFFFF, 1'b0, 4'd2}, // R2
    '{3'd2, 16'hFFFF, 16'h1234, 16'h0000, 1'b1, 4'd3}, // R3
    '{3'd2, 16'h00FF, 16'hFFFF, 16'h0100, 1'b0, 4'd3}, // R3
    '{3'd3, 16'hABCD, 16'hFFFF, 16'hABCD, 1'b0, 4'd4}, // R4
    '{3'd1, 16'hF0F0, 16'hFF00, 16'h0FF0, 1'b0, 4'd5}, // R5
    '{3'd5, 16'hF0F0, 16'hFF00, 16'hF00F, 1'b0, 4'd6}, // R6
    '{3'd4, 16'hFFFF, 16'hFFFF, 16'h0000, 1'b0, 4'd7}, // R7
    '{3'd7, 16'h1234, 16'h5678, 16'h0000, 1'b0, 4'd7}  // R7
  };

  // model written from the requirements: returns {carry, result}
  function automatic logic [16:0] model(logic [2:0] op, logic [15:0] a, logic [15:0] b);
    logic [16:0] r;
    case (op)
      3'd0: r = {1'b0, a} + {1'b0, b};
      3'd6: r = {(b >= a), 16'(b - a)};
      3'd2: r = {1'b0, a} + 17'd1;
      3'd3: r = {1'b0, a};
      3'd1: r = {1'b0, a ^ b};
      3'd5: r = {1'b0, ~(a ^ b)};
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string reqOf(logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd6: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd1: return "R5";
      3'd5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic apply(logic [2:0] op, logic [15:0] a, logic [15:0] b);
    @(negedge clk);
    opSel = op;
    opA   = a;
    opB   = b;
    @(posedge clk);
    #1;
  endtask

  task automatic check(string tag, logic [15:0] expRes, logic expCo);
    nChecks++;
    if (result !== expRes || carryOut !== expCo) begin
      nFails++;
      $display("FAIL %s op=%0d a=%h b=%h: result=%h carry=%b expected result=%h carry=%b",
               tag, opSel, opA, opB, result, carryOut, expRes, expCo);
    end
  endtask

  initial begin
    logic [31:0] lfsr = 32'hACE1_2468;
    logic [16:0] exp;

    // reset state: all inputs low gives a zero sum (R1)
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", 16'h0000, 1'b0);
    rst = 1'b0;

    // table of directed vectors
    for (int i = 0; i < NVEC; i++) begin
      apply(VECS[i].op, VECS[i].a, VECS[i].b);
      check($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].expRes, VECS[i].expCo);
    end

    // R9: operand B must not influence INC or PASS
    for (int k = 0; k < 4; k++) begin
      logic [15:0] bv;
      bv = (k == 0) ? 16'h0000 : (k == 1) ? 16'hFFFF : (k == 2) ? 16'h5A5A : 16'h8001;
      apply(3'd2, 16'h7FFF, bv);
      check("R9 inc", 16'h8000, 1'b0);
      apply(3'd3, 16'h0F0F, bv);
      check("R9 pass", 16'h0F0F, 1'b0);
    end

    // R8: one-bit carries entering each group boundary
    for (int g = 1; g < 4; g++) begin
      logic [15:0] av;
      av = 16'((32'h1 << (4 * g)) - 1);
      apply(3'd0, av, 16'h0001);
      check("R8 group edge", 16'(av + 16'h0001), 1'b0);
    end

    // random operands across every code, against the model
    for (int n = 0; n < 400; n++) begin
      for (int op = 0; op < 8; op++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        apply(3'(op), lfsr[15:0], lfsr[31:16]);
        exp = model(3'(op), lfsr[15:0], lfsr[31:16]);
        check(reqOf(3'(op)), exp[15:0], exp[16]);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule